// File: doc/BRIEF.md
# Square-Wave Count-by-Two Timer

This block is a 14-bit interval timer that counts rising edges of an asynchronous timer input and drives a single output pin. The timer input is first brought into the system clock domain through a short flop chain, and each rising edge found there advances the timer by one input period. A programmed count length N splits every output cycle into a high half of ceil(N/2) input periods followed by a low half of floor(N/2) input periods. Internally the counter steps down by two and runs through each half in turn, so an odd N makes the high half one period longer than the low half.

Software loads N in two byte writes. The upper byte also carries two output-mode bits, which select square wave or pulse and single-shot or auto-reload. A separate 2-bit command strobe starts, halts, or halts the timer at the end of the current cycle. A start issued while the timer runs is held until the current cycle completes. Each completed cycle sets a sticky flag, which a status-read strobe clears. Register address decoding sits outside the block.

Top module: `sqtimer`

## Requirements
- R1: A low-byte write stores count bits 7:0. A high-byte write stores count bits 13:8 from data bits 5:0 and the output mode from data bits 7:6. Mode bit 7 = 1 selects pulse output, and mode bit 6 = 1 selects auto-reload.
- R2: After a start with count N, the output is high for the first ceil(N/2) rising edges of the timer input and low for the next floor(N/2). Each rising edge counts once, however long the input stays high. The output is high while the timer is idle.
- R3: Mode 00 (single square wave) produces exactly one cycle. The timer then stops with the output high, and further input edges neither change the output nor set the flag.
- R4: Mode 01 (continuous square wave) reloads the same count at each cycle end and repeats the waveform without a gap.
- R5: In the pulse modes the output is low only during the last input period of each cycle, that is, after edge N-1 and before edge N. Mode 10 does this once and then stops. Mode 11 repeats it.
- R6: A start command (code 11) given while idle with a count below 2 is ignored, and the timer stays idle.
- R7: Command 01 stops a running timer at once, and the output returns high. Command 00 has no effect on a running timer.
- R8: Command 10 lets the current cycle finish and then stops the timer.
- R9: A start command given while running is deferred to the next cycle end. The timer then switches to the count and mode that were held in the length register when the command was given.
- R10: Writing new count or mode bytes while running, without a start command, leaves the running waveform unchanged.
- R11: Every cycle end sets a sticky terminal-count flag. A status-read strobe or a reset clears it.
- R12: Reset stops counting and sets the output high, but keeps the count and mode. Counting resumes only after a start command, which then uses the kept values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tin | input | 1 | Timer input, asynchronous to clk |
| len_lo_we | input | 1 | Write strobe for the count low byte |
| len_hi_we | input | 1 | Write strobe for the count high byte and the mode bits |
| wdata | input | 8 | Write data for both length bytes |
| cmd_we | input | 1 | Command strobe |
| cmd | input | 2 | Command code: 00 none, 01 halt, 10 halt at cycle end, 11 start |
| stat_rd | input | 1 | Status-read strobe that clears the flag |
| tout | output | 1 | Timer output level |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
The bound checker checks the following on every cycle:
- the output moves only on a synchronised input edge or a command;
- each terminal count sets the flag, and a read clears it;
- the flag never rises without a terminal count;
- a halt takes effect at once;
- a single-shot cycle end leaves the timer idle;
- a start with a count below 2 is refused.

Other behaviours can only be seen through the directed scenarios, because they depend on whole sequences of input edges:
- the exact high and low half lengths for odd and even counts;
- where the pulse falls in the cycle;
- the deferred start and its switch to the new mode;
- that the count and mode survive a reset.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_HALT    = 2'b01,
    CMD_HALT_TC = 2'b10,
    CMD_GO      = 2'b11
  } tmr_cmd_e;

  // Mode field: bit 1 selects pulse output, bit 0 selects auto-reload.
  localparam int MODE_PULSE_BIT  = 1;
  localparam int MODE_REPEAT_BIT = 0;
  localparam int MODE_W          = 2;
  localparam int BYTE_W          = 8;

endpackage

// File: rtl/sqt_sync.sv
module sqt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tin,
  output logic tin_rise
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], tin};
  end

  // The bit after the last synchroniser stage holds the previous sample.
  assign tin_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sqt_lenreg.sv
module sqt_lenreg
  import sqt_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic                 clk,
  input  logic                 len_lo_we,
  input  logic                 len_hi_we,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [CNT_W-1:0]     len_val,
  output logic [MODE_W-1:0]    mode_val
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [MODE_W-1:0] mode_q;

  // No reset on purpose: the count and mode survive a reset.
  always_ff @(posedge clk) begin
    if (len_lo_we) lo_q <= wdata;
    if (len_hi_we) begin
      hi_q   <= wdata[HI_W-1:0];
      mode_q <= wdata[BYTE_W-1 -: MODE_W];
    end
  end

  assign len_val  = {hi_q, lo_q};
  assign mode_val = mode_q;
endmodule

// File: rtl/sqt_core.sv
module sqt_core
  import sqt_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tin_rise,
  input  logic              cmd_we,
  input  logic [1:0]        cmd,
  input  logic              stat_rd,
  input  logic [CNT_W-1:0]  len_val,
  input  logic [MODE_W-1:0] mode_val,
  output logic              active,
  output logic              tc_hit,
  output logic              start_pend,
  output logic [MODE_W-1:0] act_mode,
  output logic              tout,
  output logic              tc_flag
);
  localparam int CW = CNT_W + 1;

  // The high half starts from N rounded up to even, the low half from N rounded down.
  function automatic logic [CW-1:0] first_load(input logic [CNT_W-1:0] n);
    return {1'b0, n} + CW'(n[0]);
  endfunction

  function automatic logic [CW-1:0] second_load(input logic [CNT_W-1:0] n);
    return {1'b0, n} - CW'(n[0]);
  endfunction

  logic [CW-1:0]     cnt;
  logic              phase_lo;
  logic              stop_pend;
  logic [CNT_W-1:0]  act_len;
  logic [CNT_W-1:0]  pend_len;
  logic [MODE_W-1:0] pend_mode;
  logic              half_end;
  logic              len_ok;
  tmr_cmd_e          cmd_e;

  assign cmd_e    = tmr_cmd_e'(cmd);
  assign len_ok   = (len_val >= CNT_W'(2));
  assign half_end = active && tin_rise && (cnt == CW'(2));
  assign tc_hit   = half_end && phase_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      phase_lo   <= 1'b0;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
      tc_flag    <= 1'b0;
    end else begin
      tc_flag <= (tc_flag & ~stat_rd) | tc_hit;

      // Advance on each synchronised input edge.
      if (tc_hit) begin
        if (start_pend) begin
          act_len    <= pend_len;
          act_mode   <= pend_mode;
          cnt        <= first_load(pend_len);
          phase_lo   <= 1'b0;
          start_pend <= 1'b0;
          stop_pend  <= 1'b0;
        end else if (stop_pend || !act_mode[MODE_REPEAT_BIT]) begin
          active    <= 1'b0;
          phase_lo  <= 1'b0;
          stop_pend <= 1'b0;
        end else begin
          cnt      <= first_load(act_len);
          phase_lo <= 1'b0;
        end
      end else if (half_end) begin
        phase_lo <= 1'b1;
        cnt      <= second_load(act_len);
      end else if (active && tin_rise) begin
        cnt <= cnt - CW'(2);
      end

      // A command overrides an edge that lands in the same cycle.
      if (cmd_we) begin
        case (cmd_e)
          CMD_HALT: begin
            active     <= 1'b0;
            phase_lo   <= 1'b0;
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
          end
          CMD_HALT_TC: begin
            if (active) begin
              stop_pend  <= 1'b1;
              start_pend <= 1'b0;
            end
          end
          CMD_GO: begin
            if (len_ok) begin
              if (!active) begin
                active   <= 1'b1;
                phase_lo <= 1'b0;
                cnt      <= first_load(len_val);
                act_len  <= len_val;
                act_mode <= mode_val;
              end else begin
                start_pend <= 1'b1;
                stop_pend  <= 1'b0;
                pend_len   <= len_val;
                pend_mode  <= mode_val;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (act_mode[MODE_PULSE_BIT]) tout = !(active && phase_lo && (cnt == CW'(2)));
    else                          tout = !(active && phase_lo);
  end
endmodule

// File: rtl/sqtimer.sv
module sqtimer
  import sqt_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tin,
  input  logic       len_lo_we,
  input  logic       len_hi_we,
  input  logic [7:0] wdata,
  input  logic       cmd_we,
  input  logic [1:0] cmd,
  input  logic       stat_rd,
  output logic       tout,
  output logic       tc_flag
);
  logic              tin_rise;
  logic              tc_hit;
  logic              active;
  logic              start_pend;
  logic [CNT_W-1:0]  len_val;
  logic [MODE_W-1:0] mode_val;
  logic [MODE_W-1:0] act_mode;

  sqt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .tin      (tin),
    .tin_rise (tin_rise)
  );

  sqt_lenreg #(.CNT_W(CNT_W)) u_len (
    .clk       (clk),
    .len_lo_we (len_lo_we),
    .len_hi_we (len_hi_we),
    .wdata     (wdata),
    .len_val   (len_val),
    .mode_val  (mode_val)
  );

  sqt_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tin_rise   (tin_rise),
    .cmd_we     (cmd_we),
    .cmd        (cmd),
    .stat_rd    (stat_rd),
    .len_val    (len_val),
    .mode_val   (mode_val),
    .active     (active),
    .tc_hit     (tc_hit),
    .start_pend (start_pend),
    .act_mode   (act_mode),
    .tout       (tout),
    .tc_flag    (tc_flag)
  );
endmodule

// File: rtl/sqt_chk.sv
module sqt_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tin_rise,
  input logic             tc_hit,
  input logic             cmd_we,
  input logic [1:0]       cmd,
  input logic             stat_rd,
  input logic [CNT_W-1:0] len_val,
  input logic             active,
  input logic             start_pend,
  input logic [1:0]       act_mode,
  input logic             tout,
  input logic             tc_flag
);
  p_tc_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit |=> tc_flag);

  p_rd_clears_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tc_hit) |=> !tc_flag);

  p_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(tc_hit));

  p_small_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd == 2'b11 && !active && len_val < CNT_W'(2)) |=> !active);

  p_quiet_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tin_rise && !cmd_we) |=> $stable(tout));

  p_single_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && !act_mode[0] && !start_pend && !cmd_we) |=> !active);

  p_halt_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd == 2'b01) |=> (!active && tout));
endmodule

bind sqtimer sqt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tin_rise   (tin_rise),
  .tc_hit     (tc_hit),
  .cmd_we     (cmd_we),
  .cmd        (cmd),
  .stat_rd    (stat_rd),
  .len_val    (len_val),
  .active     (active),
  .start_pend (start_pend),
  .act_mode   (act_mode),
  .tout       (tout),
  .tc_flag    (tc_flag)
);

// File: tb/sim_sqtimer.sv
`timescale 1ns/1ps
module sim_sqtimer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tin = 1'b0;
  logic       len_lo_we = 1'b0;
  logic       len_hi_we = 1'b0;
  logic [7:0] wdata = '0;
  logic       cmd_we = 1'b0;
  logic [1:0] cmd = '0;
  logic       stat_rd = 1'b0;
  logic       tout;
  logic       tc_flag;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  sqtimer u0 (
    .clk(clk), .rst_n(rst_n), .tin(tin), .len_lo_we(len_lo_we),
    .len_hi_we(len_hi_we), .wdata(wdata), .cmd_we(cmd_we), .cmd(cmd),
    .stat_rd(stat_rd), .tout(tout), .tc_flag(tc_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    tin = 1'b1; tick(3);
    tin = 1'b0; tick(3);
  endtask

  task automatic write_len(input int n, input int mode);
    wdata = n[7:0]; len_lo_we = 1'b1; tick(1); len_lo_we = 1'b0;
    wdata = {mode[1:0], n[13:8]}; len_hi_we = 1'b1; tick(1); len_hi_we = 1'b0;
  endtask

  task automatic command(input int c);
    cmd = c[1:0]; cmd_we = 1'b1; tick(1); cmd_we = 1'b0;
  endtask

  task automatic read_status();
    stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
  endtask

  function automatic int exp_out(input int i, input int n, input bit pulse_md);
    if (pulse_md) return ((i % n) != n - 1) ? 1 : 0;
    return ((i % n) < (n + 1) / 2) ? 1 : 0;
  endfunction

  task automatic run_seq(input int n, input int from_i, input int to_i,
                         input bit pulse_md, input string req);
    for (int i = from_i; i <= to_i; i++) begin
      pulse();
      chk(tout == exp_out(i, n, pulse_md), req, tout, exp_out(i, n, pulse_md));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  task automatic t_reset_state();
    chk(tout == 1'b1, "R12 reset tout", tout, 1);
    chk(tc_flag == 1'b0, "R11 reset flag", tc_flag, 0);
  endtask

  task automatic t_cont_square_odd();
    write_len(5, 1); command(3);
    chk(tout == 1'b1, "R2 start high", tout, 1);
    run_seq(5, 1, 10, 1'b0, "R2 R4 square N=5");
    chk(tc_flag == 1'b1, "R11 flag set", tc_flag, 1);
    read_status();
    chk(tc_flag == 1'b0, "R11 flag cleared by read", tc_flag, 0);
    command(1);
  endtask

  task automatic t_even_nop_halt();
    write_len(4, 1); command(3);
    run_seq(4, 1, 2, 1'b0, "R2 square N=4");
    command(0);
    run_seq(4, 3, 6, 1'b0, "R7 nop keeps running");
    read_status();
    command(1);
    chk(tout == 1'b1, "R7 halt output high", tout, 1);
    for (int k = 0; k < 5; k++) pulse();
    chk(tout == 1'b1, "R7 halted stays high", tout, 1);
    chk(tc_flag == 1'b0, "R7 halted no flag", tc_flag, 0);
  endtask

  task automatic t_single_square();
    write_len(3, 0); command(3);
    run_seq(3, 1, 3, 1'b0, "R3 single square N=3");
    chk(tc_flag == 1'b1, "R3 single flag", tc_flag, 1);
    read_status();
    for (int k = 0; k < 4; k++) begin
      pulse();
      chk(tout == 1'b1, "R3 stopped high", tout, 1);
    end
    chk(tc_flag == 1'b0, "R3 no second cycle", tc_flag, 0);
  endtask

  task automatic t_single_pulse();
    write_len(4, 2); command(3);
    run_seq(4, 1, 4, 1'b1, "R5 single pulse N=4");
    read_status();
    for (int k = 0; k < 5; k++) begin
      pulse();
      chk(tout == 1'b1, "R5 single pulse stopped", tout, 1);
    end
    chk(tc_flag == 1'b0, "R5 single pulse no flag", tc_flag, 0);
  endtask

  task automatic t_cont_pulse();
    write_len(2, 3); command(3);
    run_seq(2, 1, 6, 1'b1, "R5 continuous pulse N=2");
    command(1); read_status();
  endtask

  task automatic t_small_count();
    write_len(1, 1); command(3);
    for (int k = 0; k < 4; k++) pulse();
    chk(tout == 1'b1, "R6 count 1 ignored tout", tout, 1);
    chk(tc_flag == 1'b0, "R6 count 1 ignored flag", tc_flag, 0);
    write_len(0, 3); command(3);
    for (int k = 0; k < 4; k++) pulse();
    chk(tc_flag == 1'b0, "R6 count 0 ignored", tc_flag, 0);
  endtask

  task automatic t_halt_after_tc();
    write_len(4, 1); command(3);
    run_seq(4, 1, 1, 1'b0, "R8 before");
    command(2);
    run_seq(4, 2, 4, 1'b0, "R8 finishes cycle");
    chk(tc_flag == 1'b1, "R8 cycle ended", tc_flag, 1);
    read_status();
    for (int k = 0; k < 4; k++) begin
      pulse();
      chk(tout == 1'b1, "R8 stopped high", tout, 1);
    end
    chk(tc_flag == 1'b0, "R8 no further cycle", tc_flag, 0);
  endtask

  task automatic t_deferred_start();
    write_len(4, 1); command(3);
    run_seq(4, 1, 1, 1'b0, "R9 old run");
    write_len(6, 3); command(3);
    run_seq(4, 2, 4, 1'b0, "R9 old count kept until TC");
    run_seq(6, 1, 12, 1'b1, "R9 new pulse mode N=6");
    command(1); read_status();
  endtask

  task automatic t_write_no_start();
    write_len(4, 1); command(3);
    run_seq(4, 1, 1, 1'b0, "R10 run");
    write_len(2, 3);
    run_seq(4, 2, 8, 1'b0, "R10 writes ignored while running");
    command(1); read_status();
  endtask

  task automatic t_reset_keeps_len();
    write_len(6, 1); command(3);
    run_seq(6, 1, 4, 1'b0, "R12 before reset");
    do_reset();
    chk(tout == 1'b1, "R12 reset stops high", tout, 1);
    for (int k = 0; k < 3; k++) pulse();
    chk(tout == 1'b1, "R12 no counting after reset", tout, 1);
    chk(tc_flag == 1'b0, "R12 no flag after reset", tc_flag, 0);
    command(3);
    run_seq(6, 1, 6, 1'b0, "R12 kept count and mode");
    command(1); read_status();
  endtask

  task automatic t_field_layout();
    int lows = 0;
    int lowpos = 0;
    // Count 257 = 0x101; high byte 0x81 holds mode 10 (single pulse).
    write_len(257, 2); command(3);
    for (int i = 1; i <= 260; i++) begin
      pulse();
      if (tout == 1'b0) begin
        lows++;
        lowpos = i;
      end
    end
    chk(lows == 1, "R1 one pulse", lows, 1);
    chk(lowpos == 256, "R1 pulse position", lowpos, 256);
  endtask

  initial begin
    tick(2);
    t_reset_state();
    rst_n = 1'b1; tick(1);
    t_cont_square_odd();
    t_even_nop_halt();
    t_single_square();
    t_single_pulse();
    t_cont_pulse();
    t_small_count();
    t_halt_after_tc();
    t_deferred_start();
    t_write_no_start();
    t_reset_keeps_len();
    t_field_layout();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule